// File: doc/BRIEF.md
# GPIO Port Pin-Change Interrupt Flags

This block gives an eight-pin input port the ability to raise an interrupt. Each pin is first brought into the clock domain through a two-flop synchronizer. It is then watched for a transition in the direction chosen by that pin's polarity bit. A detected transition latches a per-pin flag. The flags, ANDed with per-pin enable bits and ORed together, drive one shared request line toward the interrupt controller.

Software uses a small register bus. It reads the flags to learn which pin fired, and it writes the flag register to clear them. Writing a 1 to a flag raises the request without any pin activity. A flag that the service routine leaves set keeps the request high, so service begins again as soon as it returns. A hardware transition always beats a software clear of the same bit in the same cycle.

Top module: `pin_irq_port`

## Requirements
- R1: After reset the polarity, enable and flag registers read 0 and the request output is low.
- R2: Register addresses are: 0 reads the synchronized pin levels and ignores writes, 1 is polarity, 2 is enable, 3 is flags. Addresses 1, 2 and 3 read back the last value written. Read data is combinational from the address.
- R3: A pin whose polarity bit is 0 sets its flag on a 0-to-1 change. A polarity bit of 1 sets the flag on a 1-to-0 change. A pin change held from just after one rising clock edge is visible in the flag on the third rising edge.
- R4: A flag stays set until a write of 0 to that bit. While it stays set with its enable high, the request stays high.
- R5: A flag-register write loads each flag bit from the write data, so writing 1 sets a flag and raises the request with no pin activity.
- R6: The request output equals the OR over all pins of (flag AND enable).
- R7: When a detected transition and a flag write of 0 to the same bit fall in the same cycle, the flag ends up set. Other bits take the written value.
- R8: Flags are set by transitions even when the pin's enable bit is 0. The enable only gates the request.
- R9: Writing the polarity register does not set any flag, whatever the pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 8 | Asynchronous port pin levels |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data for busAddr |
| irqOut | output | 1 | Shared interrupt request |

## Verification
Every one of the 256 pin patterns is applied as a rise from all-low and then a fall back, under four polarity masks. The flag must equal the pattern masked by the inverted polarity after the rise, and by the polarity after the fall. This separates rising from falling detection per bit and shows that no pin disturbs another. The request is then swept over all 256 software-set flag values against several enable masks. This separates the AND-OR reduction from a plain OR or a single-bit tap. Directed cases cover a transition colliding with a clear, a flag left set across many cycles, polarity writes over stable high pins, and transitions with the enable off.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_LEVEL  = 2'd0,
    REG_EDGE   = 2'd1,
    REG_ENABLE = 2'd2,
    REG_FLAG   = 2'd3
  } regAddrE;

  typedef struct packed {
    logic wrEdge;
    logic wrEnable;
    logic wrFlag;
  } regStrobesT;

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= '0;
        else       stageQ[g] <= asyncIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= '0;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                  busWr,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [NUM_PINS-1:0]   levelQ,
  input  logic [NUM_PINS-1:0]   edgeSelQ,
  input  logic [NUM_PINS-1:0]   enableQ,
  input  logic [NUM_PINS-1:0]   flagQ,
  output regStrobesT            strobes,
  output logic [NUM_PINS-1:0]   busRdata
);

  regAddrE addrSel;
  assign addrSel = regAddrE'(busAddr);

  always_comb begin
    strobes = '0;
    if (busWr) begin
      unique case (addrSel)
        REG_EDGE:   strobes.wrEdge   = 1'b1;
        REG_ENABLE: strobes.wrEnable = 1'b1;
        REG_FLAG:   strobes.wrFlag   = 1'b1;
        default:    strobes          = '0;
      endcase
    end
  end

  always_comb begin
    unique case (addrSel)
      REG_LEVEL:  busRdata = levelQ;
      REG_EDGE:   busRdata = edgeSelQ;
      REG_ENABLE: busRdata = enableQ;
      default:    busRdata = flagQ;
    endcase
  end

  always_comb begin
    if (busWr) assert ($countones(strobes) <= 1) else $error("AST_ONE_STROBE"); // R2
  end

endmodule

// File: rtl/pin_irq_dpath.sv
module pin_irq_dpath
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinSync,
  input  regStrobesT          strobes,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] edgeSelQ,
  output logic [NUM_PINS-1:0] enableQ,
  output logic [NUM_PINS-1:0] flagQ,
  output logic                irq
);

  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] edgeHit;
  logic [NUM_PINS-1:0] flagBase;
  logic [NUM_PINS-1:0] maskedFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= pinSync;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    logic riseP, fallP;
    assign riseP      = pinSync[p] & ~prevQ[p];
    assign fallP      = ~pinSync[p] & prevQ[p];
    assign edgeHit[p] = edgeSelQ[p] ? fallP : riseP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeSelQ <= '0;
      enableQ  <= '0;
    end else begin
      if (strobes.wrEdge)   edgeSelQ <= wdata;
      if (strobes.wrEnable) enableQ  <= wdata;
    end
  end

  assign flagBase = strobes.wrFlag ? wdata : flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagBase | edgeHit;
  end

  assign maskedFlags = flagQ & enableQ;
  assign irq         = |maskedFlags;

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (edgeHit != '0) |=> ((flagQ & $past(edgeHit)) == $past(edgeHit))) else $error("AST_EDGE_SETS"); // R7

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrFlag |=> (($past(flagQ) & ~flagQ) == '0)) else $error("AST_FLAG_HOLD"); // R4

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.wrFlag && edgeHit == '0) |=> $stable(flagQ)) else $error("AST_NO_SPURIOUS"); // R9

  AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrFlag |=> (flagQ == ($past(wdata) | $past(edgeHit)))) else $error("AST_SW_LOAD"); // R5

endmodule

// File: rtl/pin_irq_port.sv
module pin_irq_port
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic                  busWr,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [NUM_PINS-1:0]   busWdata,
  output logic [NUM_PINS-1:0]   busRdata,
  output logic                  irqOut
);

  logic [NUM_PINS-1:0] pinSync;
  logic [NUM_PINS-1:0] edgeSelQ;
  logic [NUM_PINS-1:0] enableQ;
  logic [NUM_PINS-1:0] flagQ;
  regStrobesT          strobes;

  pin_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (pinSync)
  );

  pin_irq_ctrl #(.NUM_PINS(NUM_PINS)) uCtrl (
    .busWr    (busWr),
    .busAddr  (busAddr),
    .levelQ   (pinSync),
    .edgeSelQ (edgeSelQ),
    .enableQ  (enableQ),
    .flagQ    (flagQ),
    .strobes  (strobes),
    .busRdata (busRdata)
  );

  pin_irq_dpath #(.NUM_PINS(NUM_PINS)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .pinSync  (pinSync),
    .strobes  (strobes),
    .wdata    (busWdata),
    .edgeSelQ (edgeSelQ),
    .enableQ  (enableQ),
    .flagQ    (flagQ),
    .irq      (irqOut)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !strobes.wrFlag && !strobes.wrEnable) |=> irqOut) else $error("AST_REQ_HOLD"); // R4

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> ($past(strobes.wrFlag) || $past(strobes.wrEnable))) else $error("AST_REQ_DROP"); // R6

endmodule

// File: tb/pin_irq_port_test.sv
`timescale 1ns/1ps
module pin_irq_port_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pinIn = '0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pin_irq_port uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    tick(1);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  initial begin
    #700000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] selList [4];
    logic [7:0] enList [5];
    selList = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    enList  = '{8'h00, 8'h01, 8'h80, 8'h5A, 8'hFF};

    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    rd(2'd1, v); check("R1 polarity", v, 8'h00);
    rd(2'd2, v); check("R1 enable", v, 8'h00);
    rd(2'd3, v); check("R1 flags", v, 8'h00);
    check("R1 irq", irqOut, 1'b0);

    // R3 sweep over every pattern and several polarity masks
    foreach (selList[s]) begin
      wr(2'd1, selList[s]);
      wr(2'd3, 8'h00);
      for (int p = 0; p < 256; p++) begin
        pinIn = p[7:0];
        tick(3);
        rd(2'd3, v); check("R3 rise", v, p[7:0] & ~selList[s]);
        wr(2'd3, 8'h00);
        pinIn = 8'h00;
        tick(3);
        rd(2'd3, v); check("R3 fall", v, p[7:0] & selList[s]);
        wr(2'd3, 8'h00);
      end
    end
    // R3 latency: not yet visible after two edges
    wr(2'd1, 8'h00);
    pinIn = 8'h10;
    tick(2);
    rd(2'd3, v); check("R3 latency early", v, 8'h00);
    tick(1);
    rd(2'd3, v); check("R3 latency on time", v, 8'h10);
    pinIn = 8'h00; tick(3); wr(2'd3, 8'h00);

    // R2 register map
    pinIn = 8'hC3; tick(3); wr(2'd3, 8'h00);
    wr(2'd0, 8'h5A);
    rd(2'd0, v); check("R2 level readonly", v, 8'hC3);
    wr(2'd2, 8'h96); rd(2'd2, v); check("R2 enable readback", v, 8'h96);
    wr(2'd1, 8'h69); rd(2'd1, v); check("R2 polarity readback", v, 8'h69);
    rd(2'd3, v); check("R2 flags unaffected", v, 8'h00);

    // R9 polarity write over stable high pins
    wr(2'd1, 8'hFF); tick(4);
    rd(2'd3, v); check("R9 set polarity", v, 8'h00);
    wr(2'd1, 8'h00); tick(4);
    rd(2'd3, v); check("R9 clear polarity", v, 8'h00);
    check("R9 irq", irqOut, 1'b0);
    pinIn = 8'h00; tick(3); wr(2'd3, 8'h00);

    // R5 / R6 software flags against enable masks
    foreach (enList[e]) begin
      wr(2'd2, enList[e]);
      for (int f = 0; f < 256; f++) begin
        wr(2'd3, f[7:0]);
        rd(2'd3, v); check("R5 sw flag", v, f[7:0]);
        check("R6 irq", irqOut, ((f[7:0] & enList[e]) != 0));
      end
    end
    wr(2'd3, 8'h00);

    // R8 flag sets with enable off
    wr(2'd2, 8'h00);
    pinIn = 8'h04; tick(3);
    rd(2'd3, v); check("R8 flag enable off", v, 8'h04);
    check("R8 irq gated", irqOut, 1'b0);
    wr(2'd2, 8'h04);
    check("R8 irq after enable", irqOut, 1'b1);

    // R4 flag left set keeps request high
    tick(20);
    check("R4 irq held", irqOut, 1'b1);
    rd(2'd3, v); check("R4 flag held", v, 8'h04);
    wr(2'd3, 8'h00);
    check("R4 irq after clear", irqOut, 1'b0);
    pinIn = 8'h00; tick(3);

    // R7 collision of edge and clear
    wr(2'd3, 8'h00);
    pinIn = 8'h01;
    tick(2);
    busWr = 1'b1; busAddr = 2'd3; busWdata = 8'h80;
    tick(1);
    busWr = 1'b0;
    rd(2'd3, v); check("R7 edge beats clear", v, 8'h81);
    wr(2'd3, 8'h00);
    rd(2'd3, v); check("R7 later clear", v, 8'h00);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule